// File: doc/BRIEF.md
# Pulse Position Modulation Frame Decoder

This block recovers two sample values per frame from a telemetry line that carries pulse-position-modulated data. A frame opens with two sync pulses a fixed distance apart. The time from the second sync pulse to the next pulse carries the first channel's value, and the time from that pulse to the one after it carries the second channel's value. A compensation gap of any length follows, and then the next sync pair.

The raw line is passed through a synchronizer, and its rising edges are detected. A free-running interval counter is restarted at every rising edge, so the count held at an edge is the gap since the previous edge, in clock cycles. A control state machine first hunts for a gap that matches the configured sync spacing within the configured tolerance. Once it has that match, it tags the next two gaps as channel samples and emits each with a one-cycle valid strobe. A downstream dual converter consumes them. A sync mismatch or an over-long silence drops the lock.

Top module: `ppm_decoder`

## Requirements
- R1: While reset is held and after it is released, with no pulses yet, `locked`, `errFlag` and `sampleValid` are all 0.
- R2: While unlocked, a gap between two rising edges of `pulseIn` whose length in clock cycles lies within `syncGap` ± `syncTol` (inclusive) sets `locked` to 1.
- R3: While unlocked, measured gaps never produce a `sampleValid` pulse.
- R4: When locked, the first gap after the sync pair is output as a sample with `sampleChan` = 0 and `sampleData` equal to the gap length in cycles.
- R5: The gap that follows is output as a sample with `sampleChan` = 1 and `sampleData` equal to its length in cycles.
- R6: The compensation gap after the second channel produces no sample. The gap after it must match the sync spacing to keep the lock, and the sync gaps produce no sample.
- R7: If the gap that should be the sync gap of a locked frame falls outside `syncGap` ± `syncTol`, `locked` drops to 0 and `errFlag` stays 0.
- R8: With the default two-stage synchronizer, `sampleValid` rises in the cycle after the third rising clock edge that samples `pulseIn` high, and stays high for exactly one cycle.
- R9: If, while locked, `TIMEOUT_CYC` cycles pass without a rising edge on `pulseIn`, `locked` drops to 0 and `errFlag` becomes 1. `errFlag` clears when lock is regained.
- R10: The interval counter saturates at 2^`CNT_W`−1, so any longer gap measures as exactly that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Raw asynchronous pulse line |
| syncGap | input | CNT_W | Expected sync spacing in cycles |
| syncTol | input | CNT_W | Allowed deviation from the sync spacing |
| sampleData | output | CNT_W | Measured gap of the latest sample |
| sampleChan | output | 1 | Channel tag: 0 = first channel, 1 = second channel |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| locked | output | 1 | Frame alignment held |
| errFlag | output | 1 | Lock lost through timeout |

## Verification
A rise on `pulseIn` takes two synchronizer flops to become an edge, and the sample register adds one more. The resulting strobe is therefore due three clock edges after the line is first sampled high, and `locked` changes on that same edge. The bench drives every rise one nanosecond after a clock edge and samples on falling edges. It checks the strobe on falling edges one through five after the rise, and each lock-state check waits four falling edges. Each such wait is subtracted from the next gap, so the gap lengths the bench expects stay exact. Sample values are collected by a falling-edge monitor and compared after each frame.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CH1,
    ST_CH2,
    ST_COMP,
    ST_SYNC2
  } ppmState_e;

  typedef struct packed {
    logic emit;
    logic chanSel;
  } ppmStrobe_t;

endpackage

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] syncGap,
  input  logic [CNT_W-1:0] syncTol,
  input  ppmStrobe_t       strobe,
  output logic             riseEdge,
  output logic             syncMatch,
  output logic             timeoutHit,
  output logic [CNT_W-1:0] sampleData,
  output logic             sampleChan,
  output logic             sampleValid
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TMO_LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [SYNC_STAGES:0] syncSh;
  logic [CNT_W-1:0]     gapCnt;
  logic [CNT_W-1:0]     gapDist;

  // input synchronizer plus one delay flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[SYNC_STAGES-1:0], pulseIn};
  end

  assign riseEdge = syncSh[SYNC_STAGES-1] & ~syncSh[SYNC_STAGES];

  // interval counter: restarts at 1 on an edge, otherwise climbs and saturates
  always_ff @(posedge clk) begin
    if (!rstN)              gapCnt <= '0;
    else if (riseEdge)      gapCnt <= CNT_W'(1);
    else if (gapCnt != CNT_MAX) gapCnt <= gapCnt + 1'b1;
  end

  always_comb begin
    if (gapCnt >= syncGap) gapDist = gapCnt - syncGap;
    else                   gapDist = syncGap - gapCnt;
  end

  assign syncMatch  = (gapDist <= syncTol);
  assign timeoutHit = (gapCnt >= TMO_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleData  <= '0;
      sampleChan  <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.emit;
      if (strobe.emit) begin
        sampleData <= gapCnt;
        sampleChan <= strobe.chanSel;
      end
    end
  end

  AST_VALID_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(riseEdge)) else $error("valid without edge"); // R8

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid) else $error("valid wider than one cycle"); // R8

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt == CNT_MAX && !riseEdge) |=> gapCnt == CNT_MAX) else $error("counter wrapped"); // R10

endmodule

// File: rtl/ppm_control.sv
module ppm_control
  import ppm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       riseEdge,
  input  logic       syncMatch,
  input  logic       timeoutHit,
  output ppmStrobe_t strobe,
  output logic       locked,
  output logic       errFlag
);

  ppmState_e state, stateNext;
  logic      errSet, errClr;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    errSet    = 1'b0;
    errClr    = 1'b0;
    unique case (state)
      ST_HUNT: if (riseEdge && syncMatch) begin
        stateNext = ST_CH1;
        errClr    = 1'b1;
      end
      ST_CH1: if (riseEdge) begin
        stateNext      = ST_CH2;
        strobe.emit    = 1'b1;
        strobe.chanSel = 1'b0;
      end
      ST_CH2: if (riseEdge) begin
        stateNext      = ST_COMP;
        strobe.emit    = 1'b1;
        strobe.chanSel = 1'b1;
      end
      ST_COMP: if (riseEdge) stateNext = ST_SYNC2;
      ST_SYNC2: if (riseEdge) stateNext = syncMatch ? ST_CH1 : ST_HUNT;
      default: stateNext = ST_HUNT;
    endcase
    if (state != ST_HUNT && !riseEdge && timeoutHit) begin
      stateNext = ST_HUNT;
      errSet    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (errSet)      errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  assign locked = (state != ST_HUNT);

  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(riseEdge && syncMatch)) else $error("lock without sync match"); // R2

  AST_SYNC_MISS_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC2 && riseEdge && !syncMatch) |=> (!locked && !errFlag)) else $error("sync miss kept lock"); // R7

  AST_ERR_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !locked) else $error("error while locked"); // R9

  AST_EMIT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> locked) else $error("sample while hunting"); // R3

endmodule

// File: rtl/ppm_decoder.sv
module ppm_decoder
  import ppm_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] syncGap,
  input  logic [CNT_W-1:0] syncTol,
  output logic [CNT_W-1:0] sampleData,
  output logic             sampleChan,
  output logic             sampleValid,
  output logic             locked,
  output logic             errFlag
);

  ppmStrobe_t strobe;
  logic       riseEdge;
  logic       syncMatch;
  logic       timeoutHit;

  ppm_datapath #(
    .CNT_W      (CNT_W),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .pulseIn    (pulseIn),
    .syncGap    (syncGap),
    .syncTol    (syncTol),
    .strobe     (strobe),
    .riseEdge   (riseEdge),
    .syncMatch  (syncMatch),
    .timeoutHit (timeoutHit),
    .sampleData (sampleData),
    .sampleChan (sampleChan),
    .sampleValid(sampleValid)
  );

  ppm_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .riseEdge  (riseEdge),
    .syncMatch (syncMatch),
    .timeoutHit(timeoutHit),
    .strobe    (strobe),
    .locked    (locked),
    .errFlag   (errFlag)
  );

endmodule

// File: tb/ppm_decoder_tb.sv
`timescale 1ns/1ps
module ppm_decoder_tb;

  localparam int CNT_W = 12;
  localparam int SYNC  = 40;
  localparam int TOL   = 2;
  localparam int NVEC  = 5;
  // columns: ch1 gap, ch2 gap, compensation gap, sync gap of next frame
  localparam int VEC [NVEC][4] = '{
    '{25, 70, 90, 40},
    '{12, 200, 55, 38},
    '{150, 3, 120, 42},
    '{300, 300, 60, 41},
    '{39, 41, 80, 39}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pulseIn = 1'b0;
  logic [CNT_W-1:0] syncGap = CNT_W'(SYNC);
  logic [CNT_W-1:0] syncTol = CNT_W'(TOL);
  logic [CNT_W-1:0] sampleData;
  logic             sampleChan;
  logic             sampleValid;
  logic             locked;
  logic             errFlag;

  int checks = 0;
  int failures = 0;
  int nGot = 0;
  logic [CNT_W-1:0] gotVal [0:63];
  logic             gotCh  [0:63];

  ppm_decoder u_dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .syncGap(syncGap), .syncTol(syncTol),
    .sampleData(sampleData), .sampleChan(sampleChan), .sampleValid(sampleValid),
    .locked(locked), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && sampleValid && nGot < 64) begin
      gotVal[nGot] = sampleData;
      gotCh[nGot]  = sampleChan;
      nGot = nGot + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // next rising edge of pulseIn lands g clock cycles after the previous one
  task automatic gapPulse(input int g);
    for (int i = 0; i < g; i++) begin
      @(posedge clk);
      #1;
      pulseIn = (i == g - 1);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pulseIn = 1'b0;
    waitNeg(4);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-reqs actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    waitNeg(3);
    chk("R1 locked in reset", locked, 0);
    chk("R1 errFlag in reset", errFlag, 0);
    chk("R1 valid in reset", sampleValid, 0);
    rstN = 1'b1;
    waitNeg(3);
    chk("R1 locked after reset", locked, 0);

    // R3: gaps before lock are discarded
    gapPulse(30);
    gapPulse(100);
    gapPulse(60);
    waitNeg(4);
    chk("R3 no samples unlocked", nGot, 0);
    chk("R3 still unlocked", locked, 0);

    // R2: matching sync gap locks
    gapPulse(SYNC - 3);
    waitNeg(4);
    chk("R2 locked on sync", locked, 1);
    chk("R2 errFlag low", errFlag, 0);

    // R8: strobe timing on the channel-1 pulse (gap 60)
    gapPulse(60 - 3);
    waitNeg(1); chk("R8 valid edge+0", sampleValid, 0);
    waitNeg(1); chk("R8 valid edge+1", sampleValid, 0);
    waitNeg(1); chk("R8 valid edge+2", sampleValid, 0);
    waitNeg(1); chk("R8 valid edge+3", sampleValid, 1);
    chk("R8 data edge+3", sampleData, 60);
    waitNeg(1); chk("R8 valid one cycle", sampleValid, 0);
    gapPulse(80 - 4);
    gapPulse(100);
    gapPulse(SYNC);
    chk("R4 first frame count", nGot, 2);
    chk("R4 first frame ch1", gotVal[0], 60);
    chk("R5 first frame ch2", gotVal[1], 80);
    chk("R5 first frame tag", gotCh[1], 1);

    // vector table: R4, R5, R6 under several gap patterns
    for (int v = 0; v < NVEC; v++) begin
      base = nGot;
      gapPulse(VEC[v][0]);
      gapPulse(VEC[v][1]);
      gapPulse(VEC[v][2]);
      gapPulse(VEC[v][3]);
      chk($sformatf("R6 v%0d two samples per frame", v), nGot - base, 2);
      chk($sformatf("R4 v%0d ch1 value", v), gotVal[base], VEC[v][0]);
      chk($sformatf("R4 v%0d ch1 tag", v), gotCh[base], 0);
      chk($sformatf("R5 v%0d ch2 value", v), gotVal[base+1], VEC[v][1]);
      chk($sformatf("R5 v%0d ch2 tag", v), gotCh[base+1], 1);
      chk($sformatf("R6 v%0d lock kept", v), locked, 1);
    end

    // R7: sync gap out of tolerance drops lock without error
    gapPulse(20);
    gapPulse(30);
    gapPulse(50);
    gapPulse(SYNC + TOL + 1);
    waitNeg(4);
    chk("R7 unlocked on sync miss", locked, 0);
    chk("R7 no error on sync miss", errFlag, 0);
    base = nGot;
    gapPulse(25 - 3);
    gapPulse(70);
    waitNeg(4);
    chk("R3 no samples after unlock", nGot - base, 0);

    // R9: timeout
    gapPulse(SYNC - 3);
    waitNeg(4);
    chk("R9 relocked before timeout", locked, 1);
    waitNeg(1200);
    chk("R9 unlocked by timeout", locked, 0);
    chk("R9 error raised", errFlag, 1);
    gapPulse(5);
    gapPulse(SYNC);
    waitNeg(4);
    chk("R9 relock", locked, 1);
    chk("R9 error cleared on relock", errFlag, 0);

    // R10: saturation, sync spacing set to counter maximum
    syncGap = {CNT_W{1'b1}};
    syncTol = '0;
    doReset();
    gapPulse(10);
    gapPulse(5000);
    waitNeg(4);
    chk("R10 saturated gap matches max", locked, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule